// File: doc/BRIEF.md
# Clock Output Mode and Stop Controller

This block is the digital control shell that sits between a clock synthesizer and its output pins. The clocks that the synthesizer has already produced come in as plain digital signals: a CPU-rate clock, a BUS-rate clock, a 48 MHz clock, a 24 MHz clock and the crystal reference. The block decides what each output group carries. The choices are the synthesized clock, a divided-down copy of the reference for board test, a driven-low level, or high impedance. It also tells the synthesizer which frequency pair to build.

Two frequency-select straps are captured once, just after power-on reset is released. A third select bit stays live and can be flipped at run time. Power-down forces every output low and reports the PLL and the oscillator as off. Two active-low asynchronous stop inputs park the CPU/SDRAM group and the gated BUS group low. Each stop input is synchronized on falling edges of the clock it gates, so a clock is parked and released only on whole-cycle boundaries. The free-running BUS output is never affected by the BUS stop.

The control state machine runs on the rising edge of the reference. Its states are MD_LATCH (waiting to capture the straps), MD_NORM (synthesized clocks), MD_TEST (reference divisions), MD_HIZ (all groups undriven) and MD_PDOWN (all groups driven low). MD_LATCH always leaves on the first reference edge, and that same edge captures the straps. From then on every reference edge re-decodes the state. A low power-down input goes to MD_PDOWN. Otherwise, straps 11 go to MD_TEST when the live bit is 0 and to MD_HIZ when it is 1, and any other strap value goes to MD_NORM. Each stop gate has its own two-state machine, GT_RUN and GT_PARK. It moves to GT_PARK when the synchronized stop input reads low and back to GT_RUN when it reads high, and the gate resets to GT_PARK.

Top module: `clkout_ctrl`

## Requirements
- R1: Strap capture. The strap pins are captured on the first rising edge of `ref_clk` after `por_n` goes high. After that, changes on `strap_pins` do not alter `syn_sel[2:1]`. `syn_sel` is {fs2, fs1, fs0}, with `strap_pins[1]` as fs2 and `strap_pins[0]` as fs1.
- R2: Live select. `syn_sel[0]` follows the `fs0` pin at once. The operating mode follows `fs0` from the next rising edge of `ref_clk`.
- R3: `bus_div25` is 1 exactly when the captured straps are 10 (the 2.5 CPU-to-BUS ratio pair). It is 0 for any other strap value and before capture.
- R4: Normal mode (captured straps 00, 01 or 10, `pd_n` high). `cpu_out` and `sdram_out` carry `cpu_src`. `bus_out` and `busf_out` carry `bus_src`. `out48` and `out24` carry their sources. `ref_out` and `ioapic_out` carry `ref_clk`. All bits of `grp_oe` are 1.
- R5: Test mode (straps 11, `fs0`=0). `cpu_out`, `sdram_out` and `out48` carry ref/2. `bus_out`, `busf_out` and `out24` carry ref/4. `ref_out` and `ioapic_out` carry the reference. The dividers are cleared by `por_n`.
- R6: High-impedance mode (straps 11, `fs0`=1). All bits of `grp_oe` are 0. The `grp_oe` bit order is [0] CPU, [1] SDRAM, [2] BUS, [3] free BUS, [4] 48 MHz, [5] 24 MHz, [6] REF, [7] IOAPIC.
- R7: Power-down. With `pd_n` low, all clock outputs are 0, `grp_oe` is all ones, and `pll_on` and `osc_on` are 0, from the next reference edge. Power-down overrides both test mode and high-impedance mode.
- R8: CPU stop. With `cpu_stop_n` low for two falling edges of `cpu_src`, every `cpu_out` and `sdram_out` bit stays low while the BUS, 48/24 and REF outputs keep toggling. When `cpu_stop_n` goes high again, the clocks restart after the same synchronizer delay.
- R9: BUS stop. With `bus_stop_n` low for two falling edges of `bus_src`, every `bus_out` bit stays low while `busf_out` and `cpu_out` keep toggling.
- R10: Glitch-free gating. Around stop and restart, every high pulse on a gated output is a full source high phase, and every low pulse lasts at least one source low phase.
- R11: The stop inputs have no effect outside normal mode. In test mode, the CPU and BUS groups keep toggling while both stops are low.
- R12: While `por_n` is low, and before the straps are captured, every clock output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Crystal reference clock; clocks the mode machine and the dividers |
| por_n | input | 1 | Active-low power-on reset |
| cpu_src | input | 1 | Synthesized CPU-rate clock |
| bus_src | input | 1 | Synthesized BUS-rate clock |
| src48 | input | 1 | Synthesized 48 MHz clock |
| src24 | input | 1 | Synthesized 24 MHz clock |
| strap_pins | input | 2 | Frequency straps {fs2, fs1}, captured after reset |
| fs0 | input | 1 | Live frequency select bit |
| pd_n | input | 1 | Active-low power-down |
| cpu_stop_n | input | 1 | Asynchronous active-low CPU/SDRAM stop |
| bus_stop_n | input | 1 | Asynchronous active-low gated BUS stop |
| cpu_out | output | NUM_CPU | CPU clock outputs |
| sdram_out | output | NUM_SDRAM | SDRAM clock outputs |
| bus_out | output | NUM_BUS | Gated BUS clock outputs |
| busf_out | output | 1 | Free-running BUS clock output |
| out48 | output | 1 | 48 MHz output |
| out24 | output | 1 | 24 MHz output |
| ref_out | output | NUM_REF | Reference clock outputs |
| ioapic_out | output | 1 | Interrupt-controller reference output |
| grp_oe | output | 8 | Per-group output-driver enables |
| syn_sel | output | 3 | Frequency code to the synthesizer |
| bus_div25 | output | 1 | Selects the 2.5 CPU-to-BUS ratio in the synthesizer |
| pll_on | output | 1 | PLL enable to the synthesizer |
| osc_on | output | 1 | Oscillator enable |

## Verification
A mode machine left in the wrong state shows up within one reference period as wrong `grp_oe` bits, or as the wrong edge rate on the CPU and BUS groups. The rate is 1:2 or 1:4 of the reference in test mode, against the source rate in normal mode. A stop gate that is stuck, or that skips its synchronizer, shows up as a group that keeps toggling, or stays silent, two source cycles after the stop input changes. A gate that switches on the wrong edge shows up as a shortened high or low pulse, which the bench measures on every output transition around stop and restart. A strap register that keeps sampling shows up as a change in `syn_sel[2:1]` as soon as the strap pins move after capture.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    typedef enum logic [2:0] {
        MD_LATCH = 3'd0,
        MD_NORM  = 3'd1,
        MD_TEST  = 3'd2,
        MD_HIZ   = 3'd3,
        MD_PDOWN = 3'd4
    } mode_e;

    typedef enum logic {
        GT_PARK = 1'b0,
        GT_RUN  = 1'b1
    } gate_e;

    localparam int NUM_GRP = 8;
    localparam int GRP_CPU   = 0;
    localparam int GRP_SDRAM = 1;
    localparam int GRP_BUS   = 2;
    localparam int GRP_BUSF  = 3;
    localparam int GRP_48    = 4;
    localparam int GRP_24    = 5;
    localparam int GRP_REF   = 6;
    localparam int GRP_IOAPIC = 7;

    localparam logic [1:0] STRAP_SPECIAL = 2'b11;
    localparam logic [1:0] STRAP_DIV25   = 2'b10;

    function automatic mode_e decode_mode(input logic [1:0] straps,
                                          input logic live_sel,
                                          input logic pwr_n);
        mode_e m;
        if (!pwr_n)
            m = MD_PDOWN;
        else if (straps == STRAP_SPECIAL)
            m = live_sel ? MD_HIZ : MD_TEST;
        else
            m = MD_NORM;
        return m;
    endfunction

endpackage

// File: rtl/clkctl_mode_fsm.sv
module clkctl_mode_fsm
    import clkctl_pkg::*;
(
    input  logic       ref_clk,
    input  logic       por_n,
    input  logic [1:0] strap_pins,
    input  logic       fs0,
    input  logic       pd_n,
    output mode_e      mode,
    output logic [1:0] strap_q,
    output logic       strap_ok
);

    mode_e mode_nx;

    // state register and strap capture
    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n) begin
            mode    <= MD_LATCH;
            strap_q <= 2'b00;
        end else begin
            mode <= mode_nx;
            if (mode == MD_LATCH)
                strap_q <= strap_pins;
        end
    end

    // next-state decode
    always_comb begin
        unique case (mode)
            MD_LATCH: mode_nx = decode_mode(strap_pins, fs0, pd_n);
            MD_NORM,
            MD_TEST,
            MD_HIZ,
            MD_PDOWN: mode_nx = decode_mode(strap_q, fs0, pd_n);
            default:  mode_nx = MD_LATCH;
        endcase
    end

    assign strap_ok = (mode != MD_LATCH);

endmodule

// File: rtl/clkctl_ref_div.sv
module clkctl_ref_div #(
    parameter int STAGES = 2
) (
    input  logic              ref_clk,
    input  logic              por_n,
    output logic [STAGES-1:0] div_q
);

    logic [STAGES-1:0] toggle;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign toggle[k] = 1'b1;
        end else begin : g_rest
            assign toggle[k] = &div_q[k-1:0];
        end

        always_ff @(posedge ref_clk or negedge por_n) begin
            if (!por_n)
                div_q[k] <= 1'b0;
            else if (toggle[k])
                div_q[k] <= ~div_q[k];
        end
    end

endmodule

// File: rtl/clkctl_stop_gate.sv
module clkctl_stop_gate
    import clkctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic por_n,
    input  logic stop_n,
    output logic run
);

    localparam int CHAIN = (SYNC_STAGES > 1) ? SYNC_STAGES - 1 : 1;

    logic [CHAIN-1:0] chain;
    gate_e            state;
    gate_e            state_nx;

    // falling-edge synchronizer and state register: changes only in low phase
    always_ff @(negedge src_clk or negedge por_n) begin
        if (!por_n) begin
            chain <= '0;
            state <= GT_PARK;
        end else begin
            chain <= (chain << 1) | CHAIN'(stop_n);
            state <= state_nx;
        end
    end

    always_comb begin
        unique case (state)
            GT_RUN:  state_nx = chain[CHAIN-1] ? GT_RUN : GT_PARK;
            GT_PARK: state_nx = chain[CHAIN-1] ? GT_RUN : GT_PARK;
            default: state_nx = GT_PARK;
        endcase
    end

    assign run = (state == GT_RUN);

endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
    import clkctl_pkg::*;
#(
    parameter int NUM_CPU     = 4,
    parameter int NUM_SDRAM   = 6,
    parameter int NUM_BUS     = 6,
    parameter int NUM_REF     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 ref_clk,
    input  logic                 por_n,
    input  logic                 cpu_src,
    input  logic                 bus_src,
    input  logic                 src48,
    input  logic                 src24,
    input  logic [1:0]           strap_pins,
    input  logic                 fs0,
    input  logic                 pd_n,
    input  logic                 cpu_stop_n,
    input  logic                 bus_stop_n,
    output logic [NUM_CPU-1:0]   cpu_out,
    output logic [NUM_SDRAM-1:0] sdram_out,
    output logic [NUM_BUS-1:0]   bus_out,
    output logic                 busf_out,
    output logic                 out48,
    output logic                 out24,
    output logic [NUM_REF-1:0]   ref_out,
    output logic                 ioapic_out,
    output logic [NUM_GRP-1:0]   grp_oe,
    output logic [2:0]           syn_sel,
    output logic                 bus_div25,
    output logic                 pll_on,
    output logic                 osc_on
);

    localparam int DIV_STAGES = 2;

    mode_e                 mode;
    logic [1:0]            strap_q;
    logic                  strap_ok;
    logic [DIV_STAGES-1:0] ref_div;
    logic                  cpu_run;
    logic                  bus_run;
    logic                  cpu_gated;
    logic                  bus_gated;

    clkctl_mode_fsm u_fsm (
        .ref_clk    (ref_clk),
        .por_n      (por_n),
        .strap_pins (strap_pins),
        .fs0        (fs0),
        .pd_n       (pd_n),
        .mode       (mode),
        .strap_q    (strap_q),
        .strap_ok   (strap_ok)
    );

    clkctl_ref_div #(.STAGES(DIV_STAGES)) u_div (
        .ref_clk (ref_clk),
        .por_n   (por_n),
        .div_q   (ref_div)
    );

    clkctl_stop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cpu_gate (
        .src_clk (cpu_src),
        .por_n   (por_n),
        .stop_n  (cpu_stop_n),
        .run     (cpu_run)
    );

    clkctl_stop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_bus_gate (
        .src_clk (bus_src),
        .por_n   (por_n),
        .stop_n  (bus_stop_n),
        .run     (bus_run)
    );

    assign cpu_gated = cpu_src & cpu_run;
    assign bus_gated = bus_src & bus_run;

    // output selection per mode
    always_comb begin
        unique case (mode)
            MD_NORM: begin
                cpu_out    = {NUM_CPU{cpu_gated}};
                sdram_out  = {NUM_SDRAM{cpu_gated}};
                bus_out    = {NUM_BUS{bus_gated}};
                busf_out   = bus_src;
                out48      = src48;
                out24      = src24;
                ref_out    = {NUM_REF{ref_clk}};
                ioapic_out = ref_clk;
                grp_oe     = '1;
            end
            MD_TEST: begin
                cpu_out    = {NUM_CPU{ref_div[0]}};
                sdram_out  = {NUM_SDRAM{ref_div[0]}};
                bus_out    = {NUM_BUS{ref_div[1]}};
                busf_out   = ref_div[1];
                out48      = ref_div[0];
                out24      = ref_div[1];
                ref_out    = {NUM_REF{ref_clk}};
                ioapic_out = ref_clk;
                grp_oe     = '1;
            end
            MD_HIZ: begin
                cpu_out    = '0;
                sdram_out  = '0;
                bus_out    = '0;
                busf_out   = 1'b0;
                out48      = 1'b0;
                out24      = 1'b0;
                ref_out    = '0;
                ioapic_out = 1'b0;
                grp_oe     = '0;
            end
            default: begin
                cpu_out    = '0;
                sdram_out  = '0;
                bus_out    = '0;
                busf_out   = 1'b0;
                out48      = 1'b0;
                out24      = 1'b0;
                ref_out    = '0;
                ioapic_out = 1'b0;
                grp_oe     = '1;
            end
        endcase
    end

    assign syn_sel   = {strap_q, fs0};
    assign bus_div25 = strap_ok && (strap_q == STRAP_DIV25);
    assign pll_on    = (mode != MD_PDOWN);
    assign osc_on    = (mode != MD_PDOWN);

endmodule

// File: rtl/clkout_ctrl_chk.sv
module clkout_ctrl_chk #(
    parameter int NUM_CPU   = 4,
    parameter int NUM_SDRAM = 6,
    parameter int NUM_BUS   = 6,
    parameter int NUM_REF   = 2
) (
    input logic                 ref_clk,
    input logic                 por_n,
    input logic                 cpu_src,
    input logic                 bus_src,
    input logic                 pd_n,
    input logic                 cpu_stop_n,
    input logic                 bus_stop_n,
    input logic [NUM_CPU-1:0]   cpu_out,
    input logic [NUM_SDRAM-1:0] sdram_out,
    input logic [NUM_BUS-1:0]   bus_out,
    input logic                 busf_out,
    input logic [NUM_REF-1:0]   ref_out,
    input logic [7:0]           grp_oe,
    input logic [2:0]           syn_sel,
    input logic                 pll_on,
    input logic                 osc_on,
    input logic                 strap_ok,
    input logic                 mode_norm
);

    // R1
    strap_hold_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
        $past(strap_ok) |-> $stable(syn_sel[2:1]));

    // R6
    hiz_oe_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
        ($past(strap_ok) && $past(pd_n) && $past(syn_sel) == 3'b111) |-> grp_oe == 8'h00);

    // R7
    pdown_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
        ($past(por_n) && !$past(pd_n)) |->
        (!pll_on && !osc_on && grp_oe == 8'hFF && cpu_out == '0 &&
         bus_out == '0 && !busf_out && ref_out == '0));

    // R8
    cpu_park_chk: assert property (@(negedge cpu_src) disable iff (!por_n)
        ($past(mode_norm, 2) && $past(mode_norm) && mode_norm &&
         !$past(cpu_stop_n, 2) && !$past(cpu_stop_n)) |->
        (cpu_out == '0 && sdram_out == '0));

    // R8
    cpu_run_chk: assert property (@(negedge cpu_src) disable iff (!por_n)
        ($past(mode_norm, 2) && $past(mode_norm) && mode_norm &&
         $past(cpu_stop_n, 2) && $past(cpu_stop_n)) |->
        (cpu_out == '1 && sdram_out == '1));

    // R9
    bus_park_chk: assert property (@(negedge bus_src) disable iff (!por_n)
        ($past(mode_norm, 2) && $past(mode_norm) && mode_norm &&
         !$past(bus_stop_n, 2) && !$past(bus_stop_n)) |->
        (bus_out == '0 && busf_out));

endmodule

bind clkout_ctrl clkout_ctrl_chk #(
    .NUM_CPU   (NUM_CPU),
    .NUM_SDRAM (NUM_SDRAM),
    .NUM_BUS   (NUM_BUS),
    .NUM_REF   (NUM_REF)
) u_chk (
    .ref_clk    (ref_clk),
    .por_n      (por_n),
    .cpu_src    (cpu_src),
    .bus_src    (bus_src),
    .pd_n       (pd_n),
    .cpu_stop_n (cpu_stop_n),
    .bus_stop_n (bus_stop_n),
    .cpu_out    (cpu_out),
    .sdram_out  (sdram_out),
    .bus_out    (bus_out),
    .busf_out   (busf_out),
    .ref_out    (ref_out),
    .grp_oe     (grp_oe),
    .syn_sel    (syn_sel),
    .pll_on     (pll_on),
    .osc_on     (osc_on),
    .strap_ok   (strap_ok),
    .mode_norm  (mode == clkctl_pkg::MD_NORM)
);

// File: tb/clkout_ctrl_test.sv
`timescale 1ns/1ps
module clkout_ctrl_test;

    localparam int NC = 4;
    localparam int NS = 6;
    localparam int NB = 6;
    localparam int NR = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0] cnt = 8'd0;
    always @(posedge clk) cnt <= cnt + 8'd1;

    // derived source clocks: cpu 10 ns, bus/48 20 ns, ref/24 40 ns
    logic cpu_src, bus_src, src48, src24, ref_clk;
    assign cpu_src = cnt[0];
    assign bus_src = cnt[1];
    assign src48   = cnt[1];
    assign src24   = cnt[2];
    assign ref_clk = cnt[2];

    logic       por_n = 1'b0;
    logic [1:0] strap_pins = 2'b00;
    logic       fs0 = 1'b0;
    logic       pd_n = 1'b1;
    logic       cpu_stop_n = 1'b1;
    logic       bus_stop_n = 1'b1;

    logic [NC-1:0] cpu_out;
    logic [NS-1:0] sdram_out;
    logic [NB-1:0] bus_out;
    logic          busf_out, out48, out24, ioapic_out;
    logic [NR-1:0] ref_out;
    logic [7:0]    grp_oe;
    logic [2:0]    syn_sel;
    logic          bus_div25, pll_on, osc_on;

    clkout_ctrl #(.NUM_CPU(NC), .NUM_SDRAM(NS), .NUM_BUS(NB), .NUM_REF(NR)) uut (
        .ref_clk(ref_clk), .por_n(por_n), .cpu_src(cpu_src), .bus_src(bus_src),
        .src48(src48), .src24(src24), .strap_pins(strap_pins), .fs0(fs0),
        .pd_n(pd_n), .cpu_stop_n(cpu_stop_n), .bus_stop_n(bus_stop_n),
        .cpu_out(cpu_out), .sdram_out(sdram_out), .bus_out(bus_out),
        .busf_out(busf_out), .out48(out48), .out24(out24), .ref_out(ref_out),
        .ioapic_out(ioapic_out), .grp_oe(grp_oe), .syn_sel(syn_sel),
        .bus_div25(bus_div25), .pll_on(pll_on), .osc_on(osc_on)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit near(input int a, input int e);
        return (a >= e - 1) && (a <= e + 1);
    endfunction

    function automatic bit exp_div25(input logic [1:0] s);
        return s == 2'b10;
    endfunction

    // edge counters over a window, sampled on the falling bench edge
    int e_cpu, e_sd, e_bus, e_busf, e_48, e_24, e_ref, e_io;
    bit hi_cpu, hi_bus, hi_any;

    task automatic watch(input int n);
        logic [7:0] prev, cur;
        e_cpu = 0; e_sd = 0; e_bus = 0; e_busf = 0;
        e_48 = 0; e_24 = 0; e_ref = 0; e_io = 0;
        hi_cpu = 0; hi_bus = 0; hi_any = 0;
        @(negedge clk);
        prev = {ioapic_out, ref_out[0], out24, out48, busf_out, bus_out[0], sdram_out[0], cpu_out[0]};
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cur = {ioapic_out, ref_out[0], out24, out48, busf_out, bus_out[0], sdram_out[0], cpu_out[0]};
            if (cur[0] && !prev[0]) e_cpu++;
            if (cur[1] && !prev[1]) e_sd++;
            if (cur[2] && !prev[2]) e_bus++;
            if (cur[3] && !prev[3]) e_busf++;
            if (cur[4] && !prev[4]) e_48++;
            if (cur[5] && !prev[5]) e_24++;
            if (cur[6] && !prev[6]) e_ref++;
            if (cur[7] && !prev[7]) e_io++;
            if ((|cpu_out) || (|sdram_out)) hi_cpu = 1;
            if (|bus_out) hi_bus = 1;
            if ((|cpu_out) || (|sdram_out) || (|bus_out) || busf_out || out48 ||
                out24 || (|ref_out) || ioapic_out) hi_any = 1;
            prev = cur;
        end
    endtask

    // R10 pulse-width monitors on gated outputs
    bit pw_on = 1'b0;
    realtime c_rise = 0, c_fall = -1, b_rise = 0, b_fall = -1;
    always @(posedge cpu_out[0]) begin
        c_rise = $realtime;
        if (pw_on && c_fall >= 0)
            check(($realtime - c_fall) >= 4.99, "R10", "cpu low width ps",
                  longint'(($realtime - c_fall) * 1000), 5000);
    end
    always @(negedge cpu_out[0]) begin
        c_fall = $realtime;
        if (pw_on)
            check(($realtime - c_rise) > 4.99 && ($realtime - c_rise) < 5.01, "R10",
                  "cpu high width ps", longint'(($realtime - c_rise) * 1000), 5000);
    end
    always @(posedge bus_out[0]) begin
        b_rise = $realtime;
        if (pw_on && b_fall >= 0)
            check(($realtime - b_fall) >= 9.99, "R10", "bus low width ps",
                  longint'(($realtime - b_fall) * 1000), 10000);
    end
    always @(negedge bus_out[0]) begin
        b_fall = $realtime;
        if (pw_on)
            check(($realtime - b_rise) > 9.99 && ($realtime - b_rise) < 10.01, "R10",
                  "bus high width ps", longint'(($realtime - b_rise) * 1000), 10000);
    end

    task automatic do_por(input logic [1:0] s, input logic f);
        pw_on = 1'b0;
        @(negedge clk);
        por_n = 1'b0; strap_pins = s; fs0 = f; pd_n = 1'b1;
        cpu_stop_n = 1'b1; bus_stop_n = 1'b1;
        watch(12);
        check(!hi_any, "R12", "output high during reset", hi_any, 0);
        @(negedge clk);
        por_n = 1'b1;
        watch(40);
        @(negedge clk);
        strap_pins = ~s;
        repeat (20) @(negedge clk);
        check(syn_sel == {s, f}, "R1", "syn_sel after strap change", syn_sel, {s, f});
        check(bus_div25 == exp_div25(s), "R3", "bus_div25", bus_div25, exp_div25(s));
    endtask

    task automatic check_normal(input string req);
        watch(128);
        check(near(e_cpu, 64), req, "cpu edges", e_cpu, 64);
        check(near(e_sd, 64), req, "sdram edges", e_sd, 64);
        check(near(e_bus, 32), req, "bus edges", e_bus, 32);
        check(near(e_busf, 32), req, "busf edges", e_busf, 32);
        check(near(e_48, 32) && near(e_24, 16), req, "48/24 edges", e_48 * 100 + e_24, 3216);
        check(near(e_ref, 16) && near(e_io, 16), req, "ref/ioapic edges", e_ref * 100 + e_io, 1616);
        check(grp_oe == 8'hFF, req, "grp_oe", grp_oe, 8'hFF);
    endtask

    initial begin
        void'($urandom(32'd2024));

        // directed: normal mode, straps 00
        do_por(2'b00, 1'b0);
        check(pll_on && osc_on, "R4", "pll/osc on", {pll_on, osc_on}, 3);
        check_normal("R4");

        // R2 live select
        @(negedge clk); fs0 = 1'b1;
        @(negedge clk);
        check(syn_sel[0] == 1'b1, "R2", "syn_sel[0] follows fs0", syn_sel[0], 1);
        repeat (20) @(negedge clk);
        check_normal("R2");

        // R8 CPU stop with pulse widths
        pw_on = 1'b1;
        @(negedge clk); cpu_stop_n = 1'b0;
        repeat (8) @(negedge clk);
        watch(64);
        check(!hi_cpu, "R8", "cpu/sdram high while stopped", hi_cpu, 0);
        check(near(e_bus, 16) && near(e_busf, 16), "R8", "bus edges while cpu stopped",
              e_bus * 100 + e_busf, 1616);
        check(near(e_ref, 8) && near(e_48, 16), "R8", "ref/48 edges while cpu stopped",
              e_ref * 100 + e_48, 816);
        @(negedge clk); cpu_stop_n = 1'b1;
        repeat (8) @(negedge clk);
        watch(64);
        check(near(e_cpu, 32) && near(e_sd, 32), "R8", "cpu restart edges", e_cpu * 100 + e_sd, 3232);

        // R9 BUS stop
        @(negedge clk); bus_stop_n = 1'b0;
        repeat (12) @(negedge clk);
        watch(64);
        check(!hi_bus, "R9", "bus high while stopped", hi_bus, 0);
        check(near(e_busf, 16), "R9", "busf edges while bus stopped", e_busf, 16);
        check(near(e_cpu, 32), "R9", "cpu edges while bus stopped", e_cpu, 32);
        @(negedge clk); bus_stop_n = 1'b1;
        repeat (12) @(negedge clk);
        watch(64);
        check(near(e_bus, 16), "R9", "bus restart edges", e_bus, 16);

        // random normal-mode strap/select combinations with random stop bursts
        for (int it = 0; it < 8; it++) begin
            logic [1:0] s;
            logic f;
            s = 2'($urandom % 3);
            f = 1'($urandom);
            do_por(s, f);
            check_normal("R4");
            pw_on = 1'b1;
            for (int b = 0; b < 6; b++) begin
                @(negedge clk);
                cpu_stop_n = 1'($urandom);
                bus_stop_n = 1'($urandom);
                repeat (3 + ($urandom % 9)) @(negedge clk);
            end
            @(negedge clk); cpu_stop_n = 1'b1; bus_stop_n = 1'b1;
            repeat (12) @(negedge clk);
            pw_on = 1'b0;
        end

        // R5 test mode and R11 stops ignored
        do_por(2'b11, 1'b0);
        watch(256);
        check(near(e_ref, 32), "R5", "ref edges", e_ref, 32);
        check(near(e_cpu, 16) && near(e_48, 16), "R5", "ref/2 edges", e_cpu * 100 + e_48, 1616);
        check(near(e_bus, 8) && near(e_24, 8) && near(e_busf, 8), "R5", "ref/4 edges",
              e_bus * 100 + e_24, 808);
        @(negedge clk); cpu_stop_n = 1'b0; bus_stop_n = 1'b0;
        repeat (16) @(negedge clk);
        watch(256);
        check(near(e_cpu, 16), "R11", "cpu edges in test with stop", e_cpu, 16);
        check(near(e_bus, 8), "R11", "bus edges in test with stop", e_bus, 8);
        @(negedge clk); cpu_stop_n = 1'b1; bus_stop_n = 1'b1;

        // R6 high impedance via live select
        @(negedge clk); fs0 = 1'b1;
        repeat (20) @(negedge clk);
        check(grp_oe == 8'h00, "R6", "grp_oe in hi-z", grp_oe, 0);

        // R7 power-down over hi-z
        @(negedge clk); pd_n = 1'b0;
        repeat (20) @(negedge clk);
        check(grp_oe == 8'hFF, "R7", "grp_oe in power-down", grp_oe, 8'hFF);
        check(!pll_on && !osc_on, "R7", "pll/osc off", {pll_on, osc_on}, 0);
        watch(64);
        check(!hi_any, "R7", "output high in power-down", hi_any, 0);
        @(negedge clk); fs0 = 1'b0;
        repeat (20) @(negedge clk);
        watch(64);
        check(!hi_any, "R7", "power-down over test mode", hi_any, 0);
        @(negedge clk); pd_n = 1'b1;
        repeat (20) @(negedge clk);
        check(pll_on && osc_on, "R7", "pll/osc back on", {pll_on, osc_on}, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule